// File: doc/BRIEF.md
# Circle and Ellipse Coordinate Table Generator

This block fills two scratch memories, one for X and one for Y, with a full period of sampled sine values. Each sample has a per-axis pixel offset added to it before it is stored. The two axes read separate sine tables in the same cycle and write both memories together. A circle is produced by starting the Y axis a quarter period after the X axis. Unequal starting phases give an ellipse.

Software loads six configuration registers, one write at a time:

- the destination block for each memory,
- the pixel offset for each axis,
- the starting phase for each axis.

Writing the Y phase starts a run. The processor ready line stays low until all points are stored. Each memory has two ports. The processor reaches every word through its own port at any time, while the generator writes through the other port.

The memories are split into 1K-word blocks, and the number of blocks is a parameter (`BLK_W` select bits). The defaults use a small block count. The full 16-block arrangement is `BLK_W = 4`.

Top module: `circ_table_gen`

## Requirements
- R1: After reset `cpu_rdy` is 1 and `done` is 0.
- R2: A write with `cfg_sel` = 5 (Y phase) while `cpu_rdy` is 1 starts a run. `cpu_rdy` is 0 for exactly 1025 cycles, starting with the cycle after the write edge.
- R3: The sample for phase p is 512 + round(511·sin(2πp/1024)), 10 bits wide. Rounding is half away from zero, so every sample lies in 1..1023.
- R4: During a run with phase P, offset O and block B, the word at address B·1024 + k (k = 0..1023) becomes O + sample((P + k) mod 1024), modulo 2^16. The phase wraps from 1023 to 0.
- R5: X and Y use their own block, offset and phase. Both memories are written in the same pass.
- R6: Configuration codes on `cfg_sel`, with data in `cfg_wdata`:
  - 0 = X block
  - 1 = Y block
  - 2 = X offset
  - 3 = Y offset
  - 4 = X phase
  - 5 = Y phase and start

  Codes 6 and 7 are ignored.
- R7: `done` is set in the cycle `cpu_rdy` returns to 1 and is cleared by the start write of the next run.
- R8: Configuration writes made while `cpu_rdy` is 0, including a Y phase write, are ignored and do not restart the run.
- R9: The processor port of each memory works independently of the generator, including during a run. A write stores `cpu_wdata` at `cpu_addr`. On a cycle with no write, the read data shows the addressed word one clock later.
- R10: Words outside the selected block of each memory are unchanged by a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register code |
| cfg_wdata | input | DW | Configuration write data |
| cpu_rdy | output | 1 | Processor ready, low while a run is in progress |
| done | output | 1 | Run-complete flag |
| cpu_addr | input | BLK_W+PHASE_W | Processor word address, shared by both memories |
| cpu_x_we | input | 1 | Processor write to the X memory |
| cpu_y_we | input | 1 | Processor write to the Y memory |
| cpu_wdata | input | DW | Processor write data |
| cpu_x_rdata | output | DW | X memory read data, one cycle latency |
| cpu_y_rdata | output | DW | Y memory read data, one cycle latency |

## Verification
Two things can fall on the same clock edge.

- **Generator write and processor access.** A generator write to one block of the X memory can coincide with a processor write to another block of that memory. The bench provokes this during an ellipse run by writing and then reading the X memory through the processor port. It judges the result from a later full readback, where both the generated words and the processor's word must be present.
- **Last store and stray configuration writes.** The final store, the release of `cpu_rdy` and the rise of `done` happen on one edge. A reference model tracks ready and done every clock. Configuration writes issued during the run must leave the stored offsets and the run length untouched.

// File: rtl/ctg_pkg.sv
package ctg_pkg;

   typedef enum logic [2:0] {
      SEL_XBLK = 3'd0,
      SEL_YBLK = 3'd1,
      SEL_XOFF = 3'd2,
      SEL_YOFF = 3'd3,
      SEL_XPH  = 3'd4,
      SEL_YPH  = 3'd5
   } cfg_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_DRAIN = 2'd2
   } seq_st_e;

   // signed sine magnitude, rounded half away from zero
   function automatic int sine_mag(input int p, input int pw, input int ow);
      real ang;
      real r;
      int  amp;
      amp = (1 << (ow - 1)) - 1;
      ang = 2.0 * 3.14159265358979323846 * real'(p) / real'(1 << pw);
      r   = real'(amp) * $sin(ang);
      if (r >= 0.0) return $rtoi(r + 0.5);
      return -$rtoi(0.5 - r);
   endfunction

endpackage

// File: rtl/ctg_sine_rom.sv
module ctg_sine_rom
   import ctg_pkg::*;
#(
   parameter int PHASE_W = 10,
   parameter int OUT_W   = 10,
   parameter bit FOLDED  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] phase,
   output logic [OUT_W-1:0]   code
);
   localparam int N   = 1 << PHASE_W;
   localparam int Q   = N / 4;
   localparam int MID = 1 << (OUT_W - 1);

   if (PHASE_W < 3) begin : g_bad_phase
      $error("ctg_sine_rom: PHASE_W must be at least 3");
   end
   if (OUT_W < 3) begin : g_bad_out
      $error("ctg_sine_rom: OUT_W must be at least 3");
   end

   if (FOLDED) begin : g_quarter
      logic [OUT_W-2:0]   mag_tbl [Q+1];
      logic [1:0]         quad;
      logic [PHASE_W-3:0] low;
      logic [PHASE_W-2:0] fidx;
      logic [OUT_W-2:0]   mag_q;
      logic               neg_q;

      for (genvar i = 0; i <= Q; i++) begin : g_ent
         assign mag_tbl[i] = (OUT_W-1)'(sine_mag(i, PHASE_W, OUT_W));
      end

      assign quad = phase[PHASE_W-1 -: 2];
      assign low  = phase[PHASE_W-3:0];

      always_comb begin
         if (quad[0]) fidx = (PHASE_W-1)'(Q) - {1'b0, low};
         else         fidx = {1'b0, low};
      end

      always_ff @(posedge clk) begin
         mag_q <= mag_tbl[fidx];
         neg_q <= quad[1];
      end

      always_comb begin
         if (neg_q) code = OUT_W'(MID) - {1'b0, mag_q};
         else       code = OUT_W'(MID) + {1'b0, mag_q};
      end
   end else begin : g_full
      logic [OUT_W-1:0] tbl [N];

      for (genvar i = 0; i < N; i++) begin : g_ent
         assign tbl[i] = OUT_W'(MID + sine_mag(i, PHASE_W, OUT_W));
      end

      always_ff @(posedge clk) begin
         code <= tbl[phase];
      end
   end

   AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      code != '0); // R3

endmodule

// File: rtl/ctg_dpram.sv
module ctg_dpram #(
   parameter int AW = 11,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_wdata;
      if (b_we) mem[b_addr] <= b_wdata;
      if (!a_we) a_rdata <= mem[a_addr];
   end

endmodule

// File: rtl/ctg_seq.sv
module ctg_seq
   import ctg_pkg::*;
#(
   parameter int PHASE_W = 10,
   parameter int BLK_W   = 1,
   parameter int DW      = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [2:0]                   cfg_sel,
   input  logic [DW-1:0]                cfg_wdata,
   output logic [1:0][PHASE_W-1:0]      rom_phase,
   output logic [1:0][BLK_W-1:0]        ax_blk,
   output logic [1:0][DW-1:0]           ax_off,
   output logic                         gen_we,
   output logic [PHASE_W-1:0]           gen_idx,
   output logic                         cpu_rdy,
   output logic                         done
);
   if (PHASE_W > DW || BLK_W > DW) begin : g_bad_w
      $error("ctg_seq: phase and block fields must fit in DW");
   end

   seq_st_e                   state;
   logic [1:0][PHASE_W-1:0]   ph_q;
   logic [PHASE_W-1:0]        idx_q;

   for (genvar a = 0; a < 2; a++) begin : g_addr
      assign rom_phase[a] = ph_q[a] + idx_q;
   end

   assign cpu_rdy = (state == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ph_q    <= '0;
         ax_blk  <= '0;
         ax_off  <= '0;
         idx_q   <= '0;
         gen_we  <= 1'b0;
         gen_idx <= '0;
         done    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cfg_we) begin
                  case (cfg_sel_e'(cfg_sel))
                     SEL_XBLK: ax_blk[0] <= cfg_wdata[BLK_W-1:0];
                     SEL_YBLK: ax_blk[1] <= cfg_wdata[BLK_W-1:0];
                     SEL_XOFF: ax_off[0] <= cfg_wdata;
                     SEL_YOFF: ax_off[1] <= cfg_wdata;
                     SEL_XPH:  ph_q[0]   <= cfg_wdata[PHASE_W-1:0];
                     SEL_YPH: begin
                        ph_q[1] <= cfg_wdata[PHASE_W-1:0];
                        idx_q   <= '0;
                        done    <= 1'b0;
                        state   <= ST_ISSUE;
                     end
                     default: ;
                  endcase
               end
            end
            ST_ISSUE: begin
               gen_we  <= 1'b1;
               gen_idx <= idx_q;
               idx_q   <= idx_q + 1'b1;
               if (idx_q == '1) state <= ST_DRAIN;
            end
            ST_DRAIN: begin
               gen_we <= 1'b0;
               done   <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_WE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      gen_we |-> !cpu_rdy); // R2

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_we && $past(gen_we)) |-> (gen_idx == PHASE_W'($past(gen_idx) + 1'b1))); // R4

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(gen_we) && ($past(gen_idx) == '1))); // R7

   AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_rdy) |-> !done); // R7

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rdy && $past(!cpu_rdy)) |-> ($stable(ax_off) && $stable(ax_blk) && $stable(ph_q))); // R8

endmodule

// File: rtl/circ_table_gen.sv
module circ_table_gen
   import ctg_pkg::*;
#(
   parameter int PHASE_W = 10,
   parameter int BLK_W   = 1,
   parameter int DW      = 16,
   parameter int OUT_W   = 10,
   parameter bit FOLDED  = 1'b1,
   localparam int AW     = BLK_W + PHASE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_sel,
   input  logic [DW-1:0] cfg_wdata,
   output logic          cpu_rdy,
   output logic          done,
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_x_we,
   input  logic          cpu_y_we,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_x_rdata,
   output logic [DW-1:0] cpu_y_rdata
);
   if (DW < OUT_W) begin : g_bad_dw
      $error("circ_table_gen: DW must hold a table sample");
   end
   if (BLK_W < 1) begin : g_bad_blk
      $error("circ_table_gen: BLK_W must be at least 1");
   end

   logic [1:0][PHASE_W-1:0] rom_phase;
   logic [1:0][BLK_W-1:0]   ax_blk;
   logic [1:0][DW-1:0]      ax_off;
   logic                    gen_we;
   logic [PHASE_W-1:0]      gen_idx;
   logic [1:0]              cpu_we_v;
   logic [1:0][DW-1:0]      cpu_rd_v;

   assign cpu_we_v    = {cpu_y_we, cpu_x_we};
   assign cpu_x_rdata = cpu_rd_v[0];
   assign cpu_y_rdata = cpu_rd_v[1];

   ctg_seq #(
      .PHASE_W (PHASE_W),
      .BLK_W   (BLK_W),
      .DW      (DW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .rom_phase (rom_phase),
      .ax_blk    (ax_blk),
      .ax_off    (ax_off),
      .gen_we    (gen_we),
      .gen_idx   (gen_idx),
      .cpu_rdy   (cpu_rdy),
      .done      (done)
   );

   for (genvar a = 0; a < 2; a++) begin : g_axis
      logic [OUT_W-1:0] code;
      logic [DW-1:0]    point;

      ctg_sine_rom #(
         .PHASE_W (PHASE_W),
         .OUT_W   (OUT_W),
         .FOLDED  (FOLDED)
      ) u_rom (
         .clk   (clk),
         .rst_n (rst_n),
         .phase (rom_phase[a]),
         .code  (code)
      );

      assign point = ax_off[a] + DW'(code);

      ctg_dpram #(
         .AW (AW),
         .DW (DW)
      ) u_ram (
         .clk     (clk),
         .a_we    (cpu_we_v[a]),
         .a_addr  (cpu_addr),
         .a_wdata (cpu_wdata),
         .a_rdata (cpu_rd_v[a]),
         .b_we    (gen_we),
         .b_addr  ({ax_blk[a], gen_idx}),
         .b_wdata (point)
      );
   end

endmodule

// File: tb/sim_circ_table_gen.sv
module sim_circ_table_gen;
   localparam int AW    = 11;
   localparam int DEPTH = 1 << AW;
   localparam int RUN   = 1025;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [15:0] cfg_wdata = '0;
   logic        cpu_rdy;
   logic        done;
   logic [AW-1:0] cpu_addr = '0;
   logic        cpu_x_we = 1'b0;
   logic        cpu_y_we = 1'b0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_x_rdata;
   logic [15:0] cpu_y_rdata;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit live   = 1'b0;

   // reference model state
   int          m_busy = 0;
   bit          m_done = 1'b0;
   int          m_blk [2];
   logic [15:0] m_off [2];
   int          m_ph  [2];
   logic [15:0] exp_x [DEPTH];
   logic [15:0] exp_y [DEPTH];

   always #5 clk = ~clk;

   circ_table_gen u0 (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
      .cfg_wdata (cfg_wdata), .cpu_rdy (cpu_rdy), .done (done),
      .cpu_addr (cpu_addr), .cpu_x_we (cpu_x_we), .cpu_y_we (cpu_y_we),
      .cpu_wdata (cpu_wdata), .cpu_x_rdata (cpu_x_rdata), .cpu_y_rdata (cpu_y_rdata)
   );

   function automatic int ref_sample(input int p);
      real r;
      r = 511.0 * $sin(2.0 * 3.14159265358979323846 * real'(p % 1024) / 1024.0);
      if (r >= 0.0) return 512 + $rtoi(r + 0.5);
      return 512 - $rtoi(0.5 - r);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // behavioural model, advanced on every rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_done = 1'b0;
         for (int a = 0; a < 2; a++) begin m_blk[a] = 0; m_off[a] = '0; m_ph[a] = 0; end
      end else begin
         if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) m_done = 1'b1;
         end else if (cfg_we) begin
            case (cfg_sel)
               3'd0: m_blk[0] = int'(cfg_wdata[0]);
               3'd1: m_blk[1] = int'(cfg_wdata[0]);
               3'd2: m_off[0] = cfg_wdata;
               3'd3: m_off[1] = cfg_wdata;
               3'd4: m_ph[0]  = int'(cfg_wdata[9:0]);
               3'd5: begin
                  m_ph[1] = int'(cfg_wdata[9:0]);
                  m_busy  = RUN;
                  m_done  = 1'b0;
                  for (int k = 0; k < 1024; k++) begin
                     exp_x[m_blk[0]*1024 + k] = m_off[0] + 16'(ref_sample(m_ph[0] + k));
                     exp_y[m_blk[1]*1024 + k] = m_off[1] + 16'(ref_sample(m_ph[1] + k));
                  end
               end
               default: ;
            endcase
         end
         if (cpu_x_we) exp_x[cpu_addr] = cpu_wdata;
         if (cpu_y_we) exp_y[cpu_addr] = cpu_wdata;
      end
   end

   // per-cycle comparison of ready and done against the model
   always @(negedge clk) begin
      if (live) begin
         check(cpu_rdy == (m_busy == 0), "R2 cpu_rdy", int'(cpu_rdy), int'(m_busy == 0));
         check(done == m_done, "R7 done", int'(done), int'(m_done));
      end
   end

   always @(posedge clk) begin
      if (cyc > 100000) begin
         fails++; checks++;
         $display("FAIL R2 watchdog expired actual=%0d expected<=%0d", cyc, 100000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic cfg_write(input logic [2:0] sel, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic readback(input string tag);
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         if (a > 0) begin
            check(cpu_x_rdata === exp_x[a-1], tag, int'(cpu_x_rdata), int'(exp_x[a-1]));
            check(cpu_y_rdata === exp_y[a-1], tag, int'(cpu_y_rdata), int'(exp_y[a-1]));
         end
         cpu_addr = AW'(a);
      end
      @(negedge clk);
      check(cpu_x_rdata === exp_x[DEPTH-1], tag, int'(cpu_x_rdata), int'(exp_x[DEPTH-1]));
      check(cpu_y_rdata === exp_y[DEPTH-1], tag, int'(cpu_y_rdata), int'(exp_y[DEPTH-1]));
   endtask

   task automatic wait_idle();
      while (!cpu_rdy) @(negedge clk);
   endtask

   initial begin
      int n;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(cpu_rdy == 1'b1, "R1 cpu_rdy after reset", int'(cpu_rdy), 1);
      check(done == 1'b0, "R1 done after reset", int'(done), 0);
      live = 1'b1;

      // R9: prefill both memories through the processor port
      for (int a = 0; a < DEPTH; a++) begin
         cpu_addr = AW'(a); cpu_wdata = 16'(a) ^ 16'h5A5A;
         cpu_x_we = 1'b1; cpu_y_we = 1'b1;
         @(negedge clk);
      end
      cpu_x_we = 1'b0; cpu_y_we = 1'b0;
      readback("R9 prefill readback");

      // circle: X from phase 0, Y a quarter period later (R4, R6)
      cfg_write(3'd0, 16'd0);
      cfg_write(3'd1, 16'd0);
      cfg_write(3'd2, 16'd100);
      cfg_write(3'd3, 16'd200);
      cfg_write(3'd4, 16'd0);
      cfg_write(3'd6, 16'd999);   // R6: unused code ignored
      cfg_write(3'd5, 16'd256);
      n = 0;
      while (!cpu_rdy) begin n++; @(negedge clk); end
      check(n == RUN, "R2 run length", n, RUN);
      check(done == 1'b1, "R7 done after circle", int'(done), 1);
      readback("R3 R4 R10 circle readback");

      // ellipse: separate blocks, wrapping offset and phase (R5)
      cfg_write(3'd0, 16'd1);
      cfg_write(3'd2, 16'hFFF0);
      cfg_write(3'd3, 16'd7);
      cfg_write(3'd4, 16'd1000);
      cfg_write(3'd5, 16'd37);
      check(done == 1'b0, "R7 done cleared by start", int'(done), 0);
      // R8: writes during the run are ignored, including a second start
      cfg_write(3'd2, 16'd5);
      cfg_write(3'd0, 16'd0);
      cfg_write(3'd5, 16'd512);
      // R9: processor write and read on the X memory while the generator writes
      @(negedge clk);
      cpu_addr = AW'(3); cpu_wdata = 16'hBEEF; cpu_x_we = 1'b1;
      @(negedge clk);
      cpu_x_we = 1'b0; cpu_addr = AW'(5);
      @(negedge clk);
      check(cpu_x_rdata == exp_x[5], "R9 read during run", int'(cpu_x_rdata), int'(exp_x[5]));
      check(cpu_rdy == 1'b0, "R8 run not restarted", int'(cpu_rdy), 0);
      wait_idle();
      check(done == 1'b1, "R7 done after ellipse", int'(done), 1);
      readback("R4 R5 R8 R9 R10 ellipse readback");

      live = 1'b0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule